// File: doc/BRIEF.md
# Platform-Level Interrupt Arbitration Controller

This block gathers up to 31 level-sensitive interrupt request lines for one hart and presents them to two privilege contexts, a machine context and a supervisor context. Each request latches into a pending set. Every source carries a 3-bit priority. Each context has its own enable mask and its own priority threshold. For each context the block asserts one interrupt line whenever that context has a source it could claim.

Software reaches the block through a plain word-wide port with an address, a write strobe, write data, a read strobe and registered read data. Each context has one claim/complete word, and that word does two jobs. Reading it returns the best eligible source for that context and moves the source from pending to in-service. Writing a source number to it ends servicing of that source. Source number 0 is reserved: it stands for "nothing to claim".

Top module: `intc_arbiter`

## Requirements
- R1: Source 0 does not exist. Its request input has no effect. Its priority word, its pending bit (bit 0 at 0x1000) and bit 0 of each enable mask always read 0. Writes to them are dropped. A claim value of 0 means no source is available.
- R2: The priority of source n is at byte offset 4*n. Only the low three bits are stored, and bits 31:3 read as 0.
- R3: The pending set reads back as one word at offset 0x1000, with bit n for source n. Writes to that word change nothing.
- R4: The machine enable mask is at 0x2000 and the supervisor enable mask is at 0x2080, with bit n enabling source n for that context.
- R5: The machine threshold is at 0x200000 and the supervisor threshold is at 0x201000, each 3 bits wide. A source is eligible for a context only if it is pending, enabled there, and its priority is strictly greater than the threshold. A threshold of 7 therefore blocks every source.
- R6: Reading a claim word (0x200004 for machine, 0x201004 for supervisor) returns the eligible source with the highest priority. On equal priority the lowest source number wins. If no source is eligible the read returns 0.
- R7: A claim that returns a non-zero source clears that source's pending bit and puts it in service. While it is in service it cannot become pending again.
- R8: Writing source number n to either claim word takes n out of service. A write of a number that is not in service, that is 0, or that is 32 or more changes nothing.
- R9: A source whose request input is high at a clock edge, and which is neither pending nor in service, becomes pending at that edge.
- R10: `irq_m` and `irq_s` are high exactly when the matching context has at least one eligible source. Each follows a change of state in the same cycle, without an added register.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. Addresses that are unmapped or not word-aligned read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_src | input | 32 | Level request lines, bit n for source n (bit 0 ignored) |
| bus_addr | input | 22 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (a claim read has side effects) |
| bus_rdata | output | 32 | Registered read data |
| irq_m | output | 1 | Machine context interrupt |
| irq_s | output | 1 | Supervisor context interrupt |

## Verification
A request raised before an edge shows up in the pending set and on the interrupt outputs after that same edge. Configuration writes also take effect at their edge, so the bench compares both interrupt lines against its reference state at the falling edge after every rising edge. Read data is due one edge after the strobe, so the expected word is computed from the reference state as it stood before that edge and compared at the following falling edge. A release written by a complete takes one more edge before a still-high request becomes pending again, and the directed sequence leaves an idle cycle there before it reads the pending word.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC_DEF   = 32;
  localparam int PRIO_W_DEF = 3;
  localparam int ADDR_W_DEF = 22;
  localparam int DATA_W_DEF = 32;
  localparam int NCTX       = 2;

  localparam int OFS_PEND     = 'h001000;
  localparam int OFS_EN_BASE  = 'h002000;
  localparam int EN_STEP      = 'h80;
  localparam int OFS_THR_BASE = 'h200000;
  localparam int THR_STEP     = 'h1000;
  localparam int CLM_DELTA    = 4;

  typedef enum logic [0:0] {CTX_MACH = 1'b0, CTX_SUP = 1'b1} ctx_e;
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import intc_pkg::*;
#(
  parameter int NSRC   = NSRC_DEF,
  parameter int PRIO_W = PRIO_W_DEF,
  parameter int DW     = DATA_W_DEF,
  localparam int ID_W  = $clog2(NSRC)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              prio_we,
  input  logic [ID_W-1:0]                   prio_wid,
  input  logic [NCTX-1:0]                   en_we,
  input  logic [NCTX-1:0]                   thr_we,
  input  logic [DW-1:0]                     wdata,
  output logic [NSRC-1:0][PRIO_W-1:0]       prio_q,
  output logic [NCTX-1:0][NSRC-1:0]         en_q,
  output logic [NCTX-1:0][PRIO_W-1:0]       thr_q
);
  localparam logic [NSRC-1:0] SRC_MASK = {{(NSRC-1){1'b1}}, 1'b0};

  logic [NSRC-1:0][PRIO_W-1:0] prio_d;
  logic [NCTX-1:0][NSRC-1:0]   en_d;
  logic [NCTX-1:0][PRIO_W-1:0] thr_d;

  always_comb begin
    prio_d = prio_q;
    if (prio_we && prio_wid != '0) prio_d[prio_wid] = wdata[PRIO_W-1:0];
    prio_d[0] = '0;
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    always_comb begin
      en_d[c]  = en_we[c]  ? (wdata[NSRC-1:0] & SRC_MASK) : en_q[c];
      thr_d[c] = thr_we[c] ? wdata[PRIO_W-1:0] : thr_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else begin
      prio_q <= prio_d;
      en_q   <= en_d;
      thr_q  <= thr_d;
    end
  end

  a_r1_src0_prio_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_q[0] == '0) && (en_q[0][0] == 1'b0) && (en_q[1][0] == 1'b0));

  a_r2_prio_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_we && prio_wid != '0) |=> (prio_q[$past(prio_wid)] == $past(wdata[PRIO_W-1:0])));
endmodule

// File: rtl/intc_src_state.sv
module intc_src_state
  import intc_pkg::*;
#(
  parameter int NSRC = NSRC_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC-1:0] claim_oh,
  input  logic [NSRC-1:0] cmp_oh,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] svc_q
);
  localparam logic [NSRC-1:0] SRC_MASK = {{(NSRC-1){1'b1}}, 1'b0};

  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] svc_d;
  logic [NSRC-1:0] arm;

  always_comb begin
    arm    = src_req & ~pend_q & ~svc_q & SRC_MASK;
    pend_d = ((pend_q & ~claim_oh) | arm) & SRC_MASK;
    svc_d  = ((svc_q & ~cmp_oh) | claim_oh) & SRC_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      svc_q  <= '0;
    end else begin
      pend_q <= pend_d;
      svc_q  <= svc_d;
    end
  end

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & svc_q) == '0);

  a_r7_claim_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_oh != '0) |=> (((pend_q & $past(claim_oh)) == '0) &&
                          ((svc_q & $past(claim_oh)) == $past(claim_oh))));

  a_r8_stray_complete: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_oh & svc_q) == '0 && claim_oh == '0) |=> $stable(svc_q));

  a_r9_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_q & $past(arm)) == $past(arm)));
endmodule

// File: rtl/intc_ctx_select.sv
module intc_ctx_select
  import intc_pkg::*;
#(
  parameter int NSRC   = NSRC_DEF,
  parameter int PRIO_W = PRIO_W_DEF,
  localparam int ID_W  = $clog2(NSRC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             pend,
  input  logic [NSRC-1:0]             en,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]           thr,
  output logic [ID_W-1:0]             best_id,
  output logic                        irq
);
  logic [NSRC-1:0]   above;
  logic [NSRC-1:0]   elig;
  logic [PRIO_W-1:0] best_p;

  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    assign above[i] = (prio[i] > thr);
  end

  always_comb begin
    elig    = pend & en & above;
    best_id = '0;
    best_p  = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (elig[i] && prio[i] > best_p) begin
        best_p  = prio[i];
        best_id = ID_W'(i);
      end
    end
    irq = |elig;
  end

  a_r6_pick_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (best_id != '0) |-> (pend[best_id] && en[best_id] && prio[best_id] > thr));

  a_r10_irq_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (best_id != '0));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NSRC   = NSRC_DEF,
  parameter int PRIO_W = PRIO_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DW     = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_src,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_m,
  output logic              irq_s
);
  localparam int ID_W = $clog2(NSRC);
  localparam logic [ADDR_W-1:0] A_PRIO_END = ADDR_W'(NSRC * 4);
  localparam logic [ADDR_W-1:0] A_PEND     = ADDR_W'(OFS_PEND);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // address decode
  logic              aligned;
  logic              hit_prio;
  logic              hit_pend;
  logic [NCTX-1:0]   hit_en;
  logic [NCTX-1:0]   hit_thr;
  logic [NCTX-1:0]   hit_clm;
  logic [ID_W-1:0]   word_id;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign hit_prio = aligned && (bus_addr < A_PRIO_END);
  assign hit_pend = (bus_addr == A_PEND);
  assign word_id  = bus_addr[ID_W+1:2];

  for (genvar c = 0; c < NCTX; c++) begin : g_dec
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_EN_BASE + c * EN_STEP);
    localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(OFS_THR_BASE + c * THR_STEP);
    localparam logic [ADDR_W-1:0] A_CLM = ADDR_W'(OFS_THR_BASE + c * THR_STEP + CLM_DELTA);
    assign hit_en[c]  = (bus_addr == A_EN);
    assign hit_thr[c] = (bus_addr == A_THR);
    assign hit_clm[c] = (bus_addr == A_CLM);
  end

  // state
  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic [NCTX-1:0][NSRC-1:0]   en_q;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q;
  logic [NSRC-1:0]             pend_q;
  logic [NSRC-1:0]             svc_q;
  logic [NCTX-1:0][ID_W-1:0]   best_id;
  logic [NCTX-1:0]             ctx_irq;
  logic [NSRC-1:0]             claim_oh;
  logic [NSRC-1:0]             cmp_oh;

  intc_cfg_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W), .DW(DW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .prio_we  (bus_wr && hit_prio),
    .prio_wid (word_id),
    .en_we    (bus_wr ? hit_en  : '0),
    .thr_we   (bus_wr ? hit_thr : '0),
    .wdata    (bus_wdata),
    .prio_q   (prio_q),
    .en_q     (en_q),
    .thr_q    (thr_q)
  );

  intc_src_state #(.NSRC(NSRC)) u_src (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .src_req  (irq_src),
    .claim_oh (claim_oh),
    .cmp_oh   (cmp_oh),
    .pend_q   (pend_q),
    .svc_q    (svc_q)
  );

  for (genvar c = 0; c < NCTX; c++) begin : g_sel
    intc_ctx_select #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_sel (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .pend    (pend_q),
      .en      (en_q[c]),
      .prio    (prio_q),
      .thr     (thr_q[c]),
      .best_id (best_id[c]),
      .irq     (ctx_irq[c])
    );
  end

  assign irq_m = ctx_irq[CTX_MACH];
  assign irq_s = ctx_irq[CTX_SUP];

  // claim and complete strobes
  always_comb begin
    claim_oh = '0;
    cmp_oh   = '0;
    for (int c = 0; c < NCTX; c++) begin
      if (bus_rd && hit_clm[c] && best_id[c] != '0) claim_oh[best_id[c]] = 1'b1;
      if (bus_wr && hit_clm[c] && bus_wdata < DW'(NSRC)) cmp_oh[bus_wdata[ID_W-1:0]] = 1'b1;
    end
  end

  // read path
  logic [DW-1:0] rd_val;
  logic [DW-1:0] rdata_d;
  logic [DW-1:0] rdata_q;

  always_comb begin
    rd_val = '0;
    if (hit_prio) rd_val = DW'(prio_q[word_id]);
    if (hit_pend) rd_val = DW'(pend_q);
    for (int c = 0; c < NCTX; c++) begin
      if (hit_en[c])  rd_val = DW'(en_q[c]);
      if (hit_thr[c]) rd_val = DW'(thr_q[c]);
      if (hit_clm[c]) rd_val = DW'(best_id[c]);
    end
    rdata_d = bus_rd ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  a_r2_prio_upper_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_rd && hit_prio) |=> (bus_rdata[DW-1:PRIO_W] == '0));

  a_r3_pend_bit0_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_rd && hit_pend) |=> (bus_rdata[0] == 1'b0));

  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_core_n)
    !bus_rd |=> $stable(bus_rdata));

  a_r6_claim_single: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(claim_oh));
endmodule

// File: tb/intc_arbiter_tb.sv
module intc_arbiter_tb;
  localparam logic [21:0] A_PEND  = 22'h001000;
  localparam logic [21:0] A_EN_M  = 22'h002000;
  localparam logic [21:0] A_EN_S  = 22'h002080;
  localparam logic [21:0] A_THR_M = 22'h200000;
  localparam logic [21:0] A_THR_S = 22'h201000;
  localparam logic [21:0] A_CLM_M = 22'h200004;
  localparam logic [21:0] A_CLM_S = 22'h201004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic [21:0] baddr = '0;
  logic        bwr = 1'b0;
  logic [31:0] bwdata = '0;
  logic        brd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_m, irq_s;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [2:0]  m_prio [32];
  logic [31:0] m_en [2];
  logic [2:0]  m_thr [2];
  logic [31:0] m_pend, m_svc;
  logic [31:0] exp_rd;
  bit          rd_done;

  always #2 clk = ~clk;

  intc_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(baddr),
    .bus_wr(bwr), .bus_wdata(bwdata), .bus_rd(brd), .bus_rdata(bus_rdata),
    .irq_m(irq_m), .irq_s(irq_s)
  );

  function automatic int best(int c);
    int bid = 0;
    int bp = 0;
    for (int i = 1; i < 32; i++)
      if (m_pend[i] && m_en[c][i] && m_prio[i] > m_thr[c] && int'(m_prio[i]) > bp) begin
        bp = int'(m_prio[i]);
        bid = i;
      end
    return bid;
  endfunction

  function automatic logic [31:0] rd_val(logic [21:0] a);
    if (a < 22'd128 && a[1:0] == 2'b00) return 32'(m_prio[a[6:2]]);
    case (a)
      A_PEND:  return m_pend;
      A_EN_M:  return m_en[0];
      A_EN_S:  return m_en[1];
      A_THR_M: return 32'(m_thr[0]);
      A_THR_S: return 32'(m_thr[1]);
      A_CLM_M: return 32'(best(0));
      A_CLM_S: return 32'(best(1));
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(logic [21:0] a);
    if (a < 22'd128) return "R2";
    case (a)
      A_PEND:           return "R3";
      A_EN_M, A_EN_S:   return "R4";
      A_THR_M, A_THR_S: return "R5";
      A_CLM_M, A_CLM_S: return "R6";
      default:          return "R11";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [31:0] ncl = '0;
    logic [31:0] ncm = '0;
    logic [31:0] narm;
    rd_done = brd;
    if (brd) begin
      exp_rd = rd_val(baddr);
      if (baddr == A_CLM_M && best(0) != 0) ncl[best(0)] = 1'b1;
      if (baddr == A_CLM_S && best(1) != 0) ncl[best(1)] = 1'b1;
    end
    if (bwr) begin
      if (baddr < 22'd128 && baddr[1:0] == 2'b00 && baddr[6:2] != 5'd0) m_prio[baddr[6:2]] = bwdata[2:0];
      if (baddr == A_EN_M)  m_en[0] = bwdata & ~32'h1;
      if (baddr == A_EN_S)  m_en[1] = bwdata & ~32'h1;
      if (baddr == A_THR_M) m_thr[0] = bwdata[2:0];
      if (baddr == A_THR_S) m_thr[1] = bwdata[2:0];
      if ((baddr == A_CLM_M || baddr == A_CLM_S) && bwdata < 32) ncm[bwdata[4:0]] = 1'b1;
    end
    narm   = irq_src & ~m_pend & ~m_svc & ~32'h1;
    m_pend = ((m_pend & ~ncl) | narm) & ~32'h1;
    m_svc  = ((m_svc & ~ncm) | ncl) & ~32'h1;
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R10 irq_m", 32'(irq_m), 32'(best(0) != 0));
    chk("R10 irq_s", 32'(irq_s), 32'(best(1) != 0));
    if (rd_done) chk(tag_of(baddr), bus_rdata, exp_rd);
  endtask

  task automatic bus_write(logic [21:0] a, logic [31:0] d);
    baddr = a; bwdata = d; bwr = 1'b1;
    cycle();
    bwr = 1'b0;
  endtask

  task automatic bus_read(logic [21:0] a, output logic [31:0] d);
    baddr = a; brd = 1'b1;
    cycle();
    brd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int unsigned seed;
    for (int i = 0; i < 32; i++) m_prio[i] = '0;
    m_en[0] = '0; m_en[1] = '0; m_thr[0] = '0; m_thr[1] = '0;
    m_pend = '0; m_svc = '0; rd_done = 0; exp_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R10 reset irq", {30'd0, irq_m, irq_s}, 32'd0);
    bus_read(A_PEND, d);  chk("R3 reset pending", d, 32'd0);
    bus_read(A_CLM_M, d); chk("R1 empty claim", d, 32'd0);

    // source 0 is inert
    irq_src = 32'h1;
    bus_write(22'h000000, 32'h7);
    bus_write(A_EN_M, 32'hFFFF_FFFF);
    cycle();
    bus_read(22'h000000, d); chk("R1 prio0", d, 32'd0);
    bus_read(A_PEND, d);     chk("R1 pend0", d, 32'd0);
    bus_read(A_EN_M, d);     chk("R1 en0", d, 32'hFFFF_FFFE);
    irq_src = '0;

    // tie on priority, lowest number first
    bus_write(22'h000014, 32'hFFFF_FFFB);   // src5 prio 3 (upper bits dropped)
    bus_write(22'h000024, 32'h3);           // src9 prio 3
    bus_write(22'h000030, 32'h6);           // src12 prio 6
    bus_read(22'h000014, d); chk("R2 prio mask", d, 32'd3);
    bus_write(A_THR_M, 32'h0);
    irq_src = (32'h1 << 5) | (32'h1 << 9);
    cycle();
    bus_read(A_CLM_M, d); chk("R6 tie low id", d, 32'd5);
    bus_read(A_CLM_M, d); chk("R6 next", d, 32'd9);
    bus_read(A_CLM_M, d); chk("R6 none left", d, 32'd0);
    bus_read(A_PEND, d);  chk("R7 in service not pending", d, 32'd0);

    // complete and re-arm
    bus_write(A_CLM_M, 32'd5);
    cycle();
    bus_read(A_PEND, d);  chk("R9 rearm after complete", d, 32'h20);
    bus_write(A_CLM_M, 32'd5);              // not in service: ignored
    bus_write(A_PEND, 32'h0);               // read-only
    bus_read(A_PEND, d);  chk("R8 stray complete ignored", d, 32'h20);

    // thresholds
    irq_src = irq_src | (32'h1 << 12);
    cycle();
    bus_write(A_THR_M, 32'h6);
    chk("R5 thr 6 blocks prio 6", 32'(irq_m), 32'd0);
    bus_write(A_THR_M, 32'h5);
    bus_read(A_CLM_M, d); chk("R5 prio 6 above thr 5", d, 32'd12);
    bus_write(A_THR_M, 32'h7);
    chk("R5 thr 7 blocks all", 32'(irq_m), 32'd0);
    bus_write(A_THR_M, 32'h0);

    // supervisor context uses its own mask
    bus_write(A_CLM_M, 32'd9);
    cycle();
    bus_write(A_EN_S, 32'h1 << 9);
    bus_read(A_EN_S, d);  chk("R4 sup mask", d, 32'h200);
    bus_read(A_CLM_S, d); chk("R6 sup claim", d, 32'd9);
    bus_read(A_CLM_S, d); chk("R6 sup empty", d, 32'd0);
    bus_read(22'h000006, d); chk("R11 misaligned", d, 32'd0);
    bus_read(22'h3FFFFC, d); chk("R11 unmapped", d, 32'd0);
    bus_write(A_CLM_S, 32'd40);             // out of range: ignored
    bus_read(A_PEND, d);  chk("R8 out of range", d, 32'h20);

    // random phase
    seed = $urandom(32'd20240611);
    for (int it = 0; it < 3000; it++) begin
      int unsigned op = $urandom_range(0, 9);
      case (op)
        0: irq_src = $urandom;
        1: bus_write(22'($urandom_range(0, 31) * 4), $urandom);
        2: bus_write($urandom_range(0, 1) ? A_EN_M : A_EN_S, $urandom);
        3: bus_write($urandom_range(0, 1) ? A_THR_M : A_THR_S, 32'($urandom_range(0, 7)));
        4, 5: bus_read($urandom_range(0, 1) ? A_CLM_M : A_CLM_S, d);
        6: bus_write($urandom_range(0, 1) ? A_CLM_M : A_CLM_S, 32'($urandom_range(0, 35)));
        7: bus_read(A_PEND, d);
        8: bus_read(22'($urandom_range(0, 31) * 4), d);
        default: cycle();
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule